// File: doc/BRIEF.md
# Multiplexed Address/Data Register Bus Slave

This block is a register slave for an 8-bit asynchronous bus on which address and data share the same lines. It has four control lines: an active-low chip select, an address-latch strobe, an active-low read strobe and an active-low write strobe. A free-running system clock samples the bus through synchroniser chains. The host first presents a register address with the latch strobe high. It then performs any number of data phases with the latch strobe low, and each one reaches that same address. The top bit of the latched address sets the direction: set for a write, clear for a read.

The slave holds a drive register whose bits become eight output-enable lines. It also exposes a sticky fault register that clears when read, a live status view and a read-back of the drive lines. An active-low disable input acts asynchronously: it forces every output off at once and empties the drive register.

A short configuration window follows reset. If the control lines are tied in a fixed pattern during that window, the block enters a transparent direct mode for the rest of the reset period. The pattern is select low, write low, latch low and read high. In direct mode the bus lines are copied straight onto the outputs.

Top module: `mux_bus_slave`

## Requirements
- R1: During reset and the configuration window that follows it, and in bus mode before any write, `drive_out` is 0 and `ad_oe` is 0.
- R2: When `bus_cs_n` is low and `bus_ale` is high, the slave latches `ad_in` as the address. Later data phases with `bus_ale` low all reach that address until a new one is latched.
- R3: A rising edge of `bus_wr_n` with the latched address equal to 80h loads `ad_in` into the drive register, and `drive_out` shows it. At any other time the drive register keeps its value.
- R4: A write whose latched address has bit 7 clear, or has bit 7 set but is not 80h, leaves the drive register unchanged.
- R5: A falling edge of `bus_rd_n` with address bit 7 clear captures read data onto `ad_out`, and `ad_oe` stays high while `bus_rd_n` is low. Addresses are 00h for the drive lines, 04h for the fault register and 05h for `live_stat`. Every other read address returns 00h.
- R6: `ad_oe` is low whenever select, read and write are all inactive, for a read whose address has bit 7 set, and at all times in direct mode.
- R7: Each bit of the fault register is set by a one-cycle pulse on `fault_evt` and stays set. A read of 04h returns the value and then clears the register to 00h.
- R8: Direct mode is chosen only when select, write and latch are low and read is high at the end of the configuration window. In that mode `drive_out` follows `ad_in`, and the choice holds until the next reset.
- R9: While `out_dis_n` is low, `drive_out` is 0 at once, without waiting for a clock. The drive register is cleared, so after release the outputs stay 0 in bus mode. This holds in both modes.
- R10: Strobes are ignored while `bus_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ale | input | 1 | Address latch strobe, high selects the address phase |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| ad_in | input | DW | Shared address/data lines, inbound |
| ad_out | output | DW | Read data for the shared lines |
| ad_oe | output | 1 | Enables the driver of the shared lines |
| out_dis_n | input | 1 | Asynchronous output disable, active low |
| fault_evt | input | DW | One-cycle fault event pulses, in the clk domain |
| live_stat | input | DW | Live status bits shown at address 05h |
| drive_out | output | DW | Output-enable lines |

## Verification
A corrupted latched address shows up on the very next data phase. A write then fails to reach `drive_out`, or a read returns the wrong register, about four sampling cycles after the strobe. A drive register that loads when it should not is visible on `drive_out` directly and again through the 00h read-back. A fault register that never clears, or clears at the wrong time, shows on the second read of 04h. A wrong mode decision after reset shows within a few cycles: either `ad_in` fails to pass through, or `ad_oe` asserts in direct mode.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [1:0] {
      MODE_CFG    = 2'd0,
      MODE_BUS    = 2'd1,
      MODE_DIRECT = 2'd2
   } mode_e;

   localparam int unsigned OFS_RB   = 0;
   localparam int unsigned OFS_ERR  = 4;
   localparam int unsigned OFS_STAT = 5;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int unsigned      W       = 4,
   parameter int unsigned      STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("mbs_sync needs at least two stages");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic [W-1:0] r;
      logic [W-1:0] src;
      if (g == 0) begin : g_first
         assign src = d;
      end else begin : g_next
         assign src = g_st[g-1].r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= src;
      end
   end

   assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/mbs_drive.sv
module mbs_drive #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_dis_n,
   input  logic          direct_en,
   input  logic [DW-1:0] direct_data,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] drive_q,
   output logic [DW-1:0] drive_out
);
   // Disable acts as a second asynchronous clear of the drive register.
   always_ff @(posedge clk or negedge rst_n or negedge out_dis_n) begin
      if (!rst_n)          drive_q <= '0;
      else if (!out_dis_n) drive_q <= '0;
      else if (direct_en)  drive_q <= direct_data;
      else if (wr_en)      drive_q <= wr_data;
   end

   // Gated combinationally so outputs drop before the next clock.
   assign drive_out = out_dis_n ? drive_q : '0;
endmodule

// File: rtl/mbs_regs.sv
module mbs_regs #(
   parameter int unsigned  DW     = 8,
   parameter logic [DW-1:0] A_RB   = '0,
   parameter logic [DW-1:0] A_ERR  = '0,
   parameter logic [DW-1:0] A_STAT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_hit,
   input  logic [DW-1:0] rd_addr,
   input  logic [DW-1:0] fault_evt,
   input  logic [DW-1:0] live_stat,
   input  logic [DW-1:0] drive_rb,
   output logic [DW-1:0] err_q,
   output logic [DW-1:0] rd_data
);
   logic err_rd;
   assign err_rd = rd_hit && (rd_addr == A_ERR);

   // Sticky faults; a read returns the value and clears it, keeping new events.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_q <= '0;
      else if (err_rd) err_q <= fault_evt;
      else             err_q <= err_q | fault_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else if (rd_hit) begin
         if (rd_addr == A_RB)        rd_data <= drive_rb;
         else if (rd_addr == A_ERR)  rd_data <= err_q;
         else if (rd_addr == A_STAT) rd_data <= live_stat;
         else                        rd_data <= '0;
      end
   end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
   import mbs_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_cs_n,
   input  logic          bus_ale,
   input  logic          bus_rd_n,
   input  logic          bus_wr_n,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   input  logic          out_dis_n,
   input  logic [DW-1:0] fault_evt,
   input  logic [DW-1:0] live_stat,
   output logic [DW-1:0] drive_out
);
   localparam int unsigned     DIR      = DW - 1;
   localparam int unsigned     CFG_WAIT = SYNC_STAGES + 1;
   localparam int unsigned     CW       = $clog2(CFG_WAIT + 1);
   localparam logic [DW-1:0]   A_DRIVE  = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0]   A_RB     = DW'(OFS_RB);
   localparam logic [DW-1:0]   A_ERR    = DW'(OFS_ERR);
   localparam logic [DW-1:0]   A_STAT   = DW'(OFS_STAT);

   if (DW < 8) begin : g_bad_dw
      $error("mux_bus_slave needs DW of at least 8");
   end

   // Control order {cs_n, rd_n, wr_n, ale}; reset to the idle pattern.
   logic [3:0]    ctl_s;
   logic [DW-1:0] ad_s;
   logic cs_n_s, rd_n_s, wr_n_s, ale_s;

   mbs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n),
      .d({bus_cs_n, bus_rd_n, bus_wr_n, bus_ale}), .q(ctl_s));
   mbs_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
      .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s));

   assign {cs_n_s, rd_n_s, wr_n_s, ale_s} = ctl_s;

   logic rd_n_d, wr_n_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_n_d <= 1'b1;
         wr_n_d <= 1'b1;
      end else begin
         rd_n_d <= rd_n_s;
         wr_n_d <= wr_n_s;
      end
   end

   logic wr_rise, rd_fall;
   assign wr_rise = wr_n_s & ~wr_n_d;
   assign rd_fall = ~rd_n_s & rd_n_d;

   // Mode decision at the end of the configuration window.
   mode_e         mode_q;
   logic [CW-1:0] cfg_cnt;
   logic          tie_pat;
   assign tie_pat = ~cs_n_s & ~wr_n_s & ~ale_s & rd_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_CFG;
         cfg_cnt <= '0;
      end else if (mode_q == MODE_CFG) begin
         if (cfg_cnt == CW'(CFG_WAIT)) mode_q <= tie_pat ? MODE_DIRECT : MODE_BUS;
         else                          cfg_cnt <= cfg_cnt + 1'b1;
      end
   end

   logic sel, data_ph;
   assign sel     = (mode_q == MODE_BUS) & ~cs_n_s;
   assign data_ph = sel & ~ale_s;

   logic [DW-1:0] addr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             addr_q <= '0;
      else if (sel & ale_s & rd_n_s & wr_n_s) addr_q <= ad_s;
   end

   logic wr_hit, rd_hit, drv_wr;
   assign wr_hit = data_ph & wr_rise &  addr_q[DIR];
   assign rd_hit = data_ph & rd_fall & ~addr_q[DIR];
   assign drv_wr = wr_hit & (addr_q == A_DRIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ad_oe <= 1'b0;
      else        ad_oe <= data_ph & ~rd_n_s & ~addr_q[DIR];
   end

   logic [DW-1:0] drive_q;
   logic [DW-1:0] err_q;

   mbs_drive #(.DW(DW)) u_drive (
      .clk(clk), .rst_n(rst_n), .out_dis_n(out_dis_n),
      .direct_en(mode_q == MODE_DIRECT), .direct_data(ad_s),
      .wr_en(drv_wr), .wr_data(ad_s),
      .drive_q(drive_q), .drive_out(drive_out));

   mbs_regs #(.DW(DW), .A_RB(A_RB), .A_ERR(A_ERR), .A_STAT(A_STAT)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_addr(addr_q),
      .fault_evt(fault_evt), .live_stat(live_stat), .drive_rb(drive_out),
      .err_q(err_q), .rd_data(ad_out));
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
   import mbs_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_dis_n,
   input logic          ad_oe,
   input mode_e         mode_q,
   input logic [DW-1:0] drive_q,
   input logic [DW-1:0] drive_out,
   input logic          drv_wr,
   input logic          rd_hit,
   input logic [DW-1:0] rd_addr,
   input logic [DW-1:0] err_q,
   input logic [DW-1:0] fault_evt
);
   assert_cfg_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_CFG) |-> (drive_q == '0 && !ad_oe));

   assert_drive_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_BUS && !drv_wr) |=> ($stable(drive_q) || drive_q == '0));

   assert_oe_bus_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (mode_q == MODE_BUS));

   assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && rd_addr == DW'(OFS_ERR) && fault_evt == '0) |=> (err_q == '0));

   assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_CFG) |=> $stable(mode_q));

   assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_dis_n |-> (drive_q == '0 && drive_out == '0));
endmodule

bind mux_bus_slave mbs_checker #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_dis_n(out_dis_n), .ad_oe(ad_oe),
   .mode_q(mode_q), .drive_q(drive_q), .drive_out(drive_out),
   .drv_wr(drv_wr), .rd_hit(rd_hit), .rd_addr(addr_q),
   .err_q(err_q), .fault_evt(fault_evt));

// File: tb/mux_bus_slave_bench.sv
module mux_bus_slave_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs_n = 1'b1, bus_ale = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [7:0] ad_in = '0;
   logic [7:0] ad_out;
   logic       ad_oe;
   logic       out_dis_n = 1'b1;
   logic [7:0] fault_evt = '0;
   logic [7:0] live_stat = '0;
   logic [7:0] drive_out;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0] m_drive = '0;
   logic [7:0] m_err   = '0;

   always #5 clk = ~clk;

   mux_bus_slave u_mux_bus_slave (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .out_dis_n(out_dis_n), .fault_evt(fault_evt),
      .live_stat(live_stat), .drive_out(drive_out));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a == 8'h00) return m_drive;
      if (a == 8'h04) return m_err;
      if (a == 8'h05) return live_stat;
      return 8'h00;
   endfunction

   task automatic do_reset(input bit direct);
      @(negedge clk);
      rst_n = 1'b0;
      bus_ale = 1'b0; bus_rd_n = 1'b1;
      bus_cs_n = direct ? 1'b0 : 1'b1;
      bus_wr_n = direct ? 1'b0 : 1'b1;
      ad_in = '0; m_drive = '0; m_err = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(10);
   endtask

   task automatic latch_addr(input logic [7:0] a);
      bus_cs_n = 1'b0; bus_ale = 1'b1; ad_in = a; cyc(4);
      bus_ale = 1'b0; cyc(4);
   endtask

   task automatic wr_pulse(input logic [7:0] d);
      ad_in = d; bus_wr_n = 1'b0; cyc(4);
      bus_wr_n = 1'b1; cyc(4);
   endtask

   task automatic rd_pulse(output logic [7:0] d, output logic oe);
      bus_rd_n = 1'b0; cyc(4);
      d = ad_out; oe = ad_oe;
      bus_rd_n = 1'b1; cyc(4);
   endtask

   task automatic deselect();
      bus_cs_n = 1'b1; cyc(4);
   endtask

   task automatic pulse_fault(input logic [7:0] v);
      fault_evt = v; cyc(1);
      fault_evt = '0; cyc(1);
      m_err = m_err | v;
   endtask

   task automatic read_check(input string req, input logic [7:0] a);
      logic [7:0] d;
      logic       oe;
      logic [7:0] e;
      e = exp_read(a);
      latch_addr(a);
      rd_pulse(d, oe);
      deselect();
      chk(req, oe, 1'b1);
      chk(req, d, e);
      if (a == 8'h04) m_err = '0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      logic       oe;
      void'($urandom(32'h5EED_0042));

      // R1: reset state in bus mode
      do_reset(1'b0);
      chk("R1 drive after reset", drive_out, 8'h00);
      chk("R1 oe after reset", ad_oe, 1'b0);
      chk("R6 oe idle", ad_oe, 1'b0);

      // R3: basic write
      latch_addr(8'h80); wr_pulse(8'h0F); m_drive = 8'h0F;
      chk("R3 drive write", drive_out, 8'h0F);
      // R2: second data phase, same latched address
      wr_pulse(8'h0A); m_drive = 8'h0A;
      chk("R2 repeated write", drive_out, 8'h0A);
      deselect();

      // R6: read with address bit 7 set does not drive
      latch_addr(8'h80); rd_pulse(d, oe); deselect();
      chk("R6 read with dir bit set", oe, 1'b0);
      chk("R6 drive unchanged", drive_out, 8'h0A);

      // R4: writes to bit7-clear and unknown bit7-set addresses
      latch_addr(8'h00); wr_pulse(8'hFF); deselect();
      chk("R4 write addr 00h ignored", drive_out, 8'h0A);
      latch_addr(8'h81); wr_pulse(8'hFF); deselect();
      chk("R4 write addr 81h ignored", drive_out, 8'h0A);
      read_check("R4 readback", 8'h00);

      // R10: strobes with select inactive
      bus_cs_n = 1'b1; bus_ale = 1'b1; ad_in = 8'h80; cyc(4);
      bus_ale = 1'b0; cyc(4);
      ad_in = 8'h33; bus_wr_n = 1'b0; cyc(4); bus_wr_n = 1'b1; cyc(4);
      chk("R10 write while deselected", drive_out, 8'h0A);
      bus_rd_n = 1'b0; cyc(4);
      chk("R10 oe while deselected", ad_oe, 1'b0);
      bus_rd_n = 1'b1; cyc(4);

      // R5: status and unknown read
      live_stat = 8'hC3;
      read_check("R5 live status", 8'h05);
      read_check("R5 unknown addr 07h", 8'h07);

      // R7: sticky faults, clear on read
      pulse_fault(8'h01); pulse_fault(8'h40);
      read_check("R7 fault read", 8'h04);
      read_check("R7 fault cleared", 8'h04);

      // Random mix
      for (int i = 0; i < 40; i++) begin
         int unsigned k;
         logic [7:0]  v;
         k = $urandom_range(0, 4);
         v = 8'($urandom);
         case (k)
            0: begin
               latch_addr(8'h80); wr_pulse(v); deselect(); m_drive = v;
               chk("R3 random write", drive_out, m_drive);
            end
            1: begin
               logic [7:0] a;
               a = {1'b1, v[6:0]};
               if (a == 8'h80) a = 8'hC1;
               latch_addr(a); wr_pulse(8'($urandom)); deselect();
               chk("R4 random ignored write", drive_out, m_drive);
            end
            2: begin
               logic [7:0] a;
               a = {1'b0, v[6:0]};
               read_check("R5 random read", a);
            end
            3: begin
               pulse_fault(v);
               read_check("R7 random fault read", 8'h04);
            end
            default: begin
               live_stat = v;
               read_check("R5 random status", 8'h05);
            end
         endcase
      end

      // R9: disable in bus mode
      latch_addr(8'h80); wr_pulse(8'h5A); deselect(); m_drive = 8'h5A;
      #2 out_dis_n = 1'b0; #1;
      chk("R9 immediate off", drive_out, 8'h00);
      cyc(2);
      out_dis_n = 1'b1; m_drive = 8'h00; cyc(4);
      chk("R9 register cleared", drive_out, 8'h00);
      read_check("R9 readback cleared", 8'h00);

      // R8: direct mode by tie-off pattern at reset
      do_reset(1'b1);
      for (int i = 0; i < 6; i++) begin
         logic [7:0] v;
         v = 8'($urandom);
         ad_in = v; cyc(4);
         chk("R8 direct follows bus", drive_out, v);
         chk("R6 no drive in direct mode", ad_oe, 1'b0);
      end
      ad_in = 8'hA5; cyc(4);
      #2 out_dis_n = 1'b0; #1;
      chk("R9 disable overrides direct", drive_out, 8'h00);
      cyc(3);
      chk("R9 held off in direct", drive_out, 8'h00);
      out_dis_n = 1'b1; cyc(4);
      chk("R8 direct resumes", drive_out, 8'hA5);

      // R8: back to bus mode after a plain reset
      do_reset(1'b0);
      ad_in = 8'h77; cyc(4);
      chk("R8 bus mode not transparent", drive_out, 8'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule